// File: doc/BRIEF.md
# Priority Interrupt Level Selector

This block sits next to a processor core and decides whether a level-based hard interrupt should be requested, and with which trap-type code. Each cycle it merges sixteen external level-request lines with the low bits of a software interrupt register, folds that register's two timer-match bits onto a single level, and finds the highest pending level above the core's current mask level. The resulting trap code and request flag live in two registers, so the core sees a stable request that moves only on a clock edge.

Several conditions stop a new request from being raised. While a vectored interrupt is in service, the block leaves its outputs exactly as they are, because vectored interrupts outrank every level interrupt. When the core is already inside an external-interrupt trap of higher type, the new request is held back. When interrupts are globally disabled, or nothing above the mask is pending, the request is withdrawn.

Top module: `pil_irq_select`

## Requirements
- R1: The pending vector is ext_lvl ORed with soft_int[15:0], with soft_int bit 0 (tick match) cleared before the merge; soft_int bit 16 (system-tick match) never maps to a level directly.
- R2: When soft_int bit 0 or bit 16 is set, level 14 is treated as pending.
- R3: While vec_busy is 1, hard_req and trap_idx keep their values on the next clock.
- R4: When vec_busy is 0 and the pending vector, read as an unsigned number, is below 2 shifted left by cur_lvl, the next clock gives hard_req=0 and trap_idx=0.
- R5: With vec_busy 0, int_en 1 and no nesting block, the highest pending level i above cur_lvl gives trap_idx = 9'h040 | i and hard_req=1 on the next clock.
- R6: If trap_lvl is nonzero, cur_tt[8:4] equals 5'h04 and cur_tt is greater than the candidate code, both outputs stay unchanged.
- R7: If the candidate code equals the stored trap_idx, both outputs stay unchanged.
- R8: When vec_busy is 0 and int_en is 0, the next clock gives hard_req=0 and trap_idx=0.
- R9: During reset hard_req is 0 and trap_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_lvl | input | 16 | External level request lines, bit i for level i |
| soft_int | input | 17 | Software interrupt register; bit 0 tick match, bit 16 system-tick match |
| cur_lvl | input | 4 | Current interrupt mask level of the core |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting depth |
| cur_tt | input | 9 | Trap type of the trap being serviced |
| vec_busy | input | 1 | A vectored interrupt is pending or in service |
| hard_req | output | 1 | Hard interrupt request to the core |
| trap_idx | output | 9 | Trap-type code of the requested level, 0 when none |

## Verification
The bench builds the block with its default sixteen levels, nine-bit trap codes, the timer remap enabled on level 14 and the fold-tree scan variant, which makes a full sweep of every mask level against every single-level request practical. The soft register is swept one bit at a time so that both timer bits and the cleared tick bit are seen in isolation. A long stretch of biased random stimulus then mixes nesting depths, current trap types inside and outside the external group, disable periods and vectored-busy periods against an arithmetic model that tracks the stored code.

// File: rtl/pil_pkg.sv
package pil_pkg;
   localparam int unsigned DEF_LEVELS    = 16;
   localparam int unsigned DEF_TT_W      = 9;
   localparam int unsigned DEF_TL_W      = 3;
   localparam int unsigned DEF_EXT_BASE  = 'h040;
   localparam int unsigned DEF_TICK_BIT  = 0;
   localparam int unsigned DEF_STICK_BIT = 16;
   localparam int unsigned DEF_TMR_LEVEL = 14;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_SET   = 2'd2
   } pil_act_e;
endpackage

// File: rtl/pil_pend_merge.sv
module pil_pend_merge #(
   parameter int unsigned LEVELS    = 16,
   parameter int unsigned SOFT_W    = 17,
   parameter int unsigned TICK_BIT  = 0,
   parameter int unsigned STICK_BIT = 16,
   parameter int unsigned TMR_LEVEL = 14,
   parameter bit          TMR_REMAP = 1'b1
) (
   input  logic [LEVELS-1:0] ext_lvl,
   input  logic [SOFT_W-1:0] soft_int,
   output logic [LEVELS-1:0] pend
);
   localparam logic [SOFT_W-1:0] TMR_MASK =
      (SOFT_W'(1) << TICK_BIT) | (SOFT_W'(1) << STICK_BIT);

   logic [SOFT_W-1:0] soft_clean;
   logic [LEVELS-1:0] base_pend;
   logic              tmr_hit;

   assign soft_clean = soft_int & ~TMR_MASK;
   assign base_pend  = ext_lvl | soft_clean[LEVELS-1:0];
   assign tmr_hit    = |(soft_int & TMR_MASK);

   generate
      if (TMR_REMAP) begin : g_remap
         always_comb begin
            pend = base_pend;
            if (tmr_hit) pend[TMR_LEVEL] = 1'b1;
         end
      end else begin : g_plain
         assign pend = base_pend;
      end
   endgenerate
endmodule

// File: rtl/pil_prio_scan.sv
module pil_prio_scan #(
   parameter int unsigned LEVELS    = 16,
   parameter bit          FOLD_TREE = 1'b1,
   localparam int unsigned LVL_W    = $clog2(LEVELS)
) (
   input  logic [LEVELS-1:0] pend,
   input  logic [LVL_W-1:0]  floor_lvl,
   output logic              found,
   output logic [LVL_W-1:0]  sel_lvl
);
   logic [LEVELS-1:0] elig;

   generate
      for (genvar i = 0; i < LEVELS; i++) begin : g_elig
         assign elig[i] = pend[i] && (LVL_W'(i) > floor_lvl);
      end

      if (FOLD_TREE) begin : g_tree
         logic             nv [LVL_W+1][LEVELS];
         logic [LVL_W-1:0] ni [LVL_W+1][LEVELS];
         for (genvar j = 0; j < LEVELS; j++) begin : g_leaf
            assign nv[0][j] = elig[j];
            assign ni[0][j] = LVL_W'(j);
         end
         for (genvar s = 0; s < LVL_W; s++) begin : g_stage
            for (genvar j = 0; j < LEVELS; j++) begin : g_node
               if (j < (LEVELS >> (s + 1))) begin : g_live
                  assign nv[s+1][j] = nv[s][2*j+1] | nv[s][2*j];
                  assign ni[s+1][j] = nv[s][2*j+1] ? ni[s][2*j+1] : ni[s][2*j];
               end else begin : g_idle
                  assign nv[s+1][j] = 1'b0;
                  assign ni[s+1][j] = '0;
               end
            end
         end
         assign found   = nv[LVL_W][0];
         assign sel_lvl = ni[LVL_W][0];
      end else begin : g_loop
         always_comb begin
            found   = 1'b0;
            sel_lvl = '0;
            for (int k = 0; k < LEVELS; k++) begin
               if (elig[k]) begin
                  found   = 1'b1;
                  sel_lvl = LVL_W'(k);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pil_nest_gate.sv
module pil_nest_gate #(
   parameter int unsigned TT_W     = 9,
   parameter int unsigned TL_W     = 3,
   parameter int unsigned GRP_LSB  = 4,
   parameter int unsigned EXT_BASE = 'h040
) (
   input  logic [TL_W-1:0] trap_lvl,
   input  logic [TT_W-1:0] cur_tt,
   input  logic [TT_W-1:0] cand_tt,
   output logic            block
);
   localparam logic [TT_W-1:0] BASE_V = TT_W'(EXT_BASE);

   logic in_grp;
   assign in_grp = (cur_tt[TT_W-1:GRP_LSB] == BASE_V[TT_W-1:GRP_LSB]);
   assign block  = (trap_lvl != '0) && in_grp && (cur_tt > cand_tt);
endmodule

// File: rtl/pil_irq_select.sv
module pil_irq_select
   import pil_pkg::*;
#(
   parameter int unsigned LEVELS    = DEF_LEVELS,
   parameter int unsigned TT_W      = DEF_TT_W,
   parameter int unsigned TL_W      = DEF_TL_W,
   parameter int unsigned EXT_BASE  = DEF_EXT_BASE,
   parameter int unsigned TICK_BIT  = DEF_TICK_BIT,
   parameter int unsigned STICK_BIT = DEF_STICK_BIT,
   parameter int unsigned TMR_LEVEL = DEF_TMR_LEVEL,
   parameter bit          TMR_REMAP = 1'b1,
   parameter bit          FOLD_TREE = 1'b1,
   localparam int unsigned LVL_W    = $clog2(LEVELS),
   localparam int unsigned SOFT_W   = LEVELS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] ext_lvl,
   input  logic [SOFT_W-1:0] soft_int,
   input  logic [LVL_W-1:0]  cur_lvl,
   input  logic              int_en,
   input  logic [TL_W-1:0]   trap_lvl,
   input  logic [TT_W-1:0]   cur_tt,
   input  logic              vec_busy,
   output logic              hard_req,
   output logic [TT_W-1:0]   trap_idx
);
   localparam logic [TT_W-1:0] BASE_V = TT_W'(EXT_BASE);

   generate
      if (LEVELS < 2 || (LEVELS & (LEVELS - 1)) != 0) begin : g_bad_levels
         $error("LEVELS must be a power of two of at least 2");
      end
      if (TMR_LEVEL >= LEVELS) begin : g_bad_tmr
         $error("TMR_LEVEL must name an existing level");
      end
      if (TICK_BIT >= SOFT_W || STICK_BIT >= SOFT_W) begin : g_bad_bits
         $error("timer bit positions exceed the soft register");
      end
      if (TT_W <= LVL_W || (EXT_BASE % LEVELS) != 0) begin : g_bad_base
         $error("EXT_BASE must leave the low level field clear");
      end
   endgenerate

   logic [LEVELS-1:0] pend;
   logic              found;
   logic [LVL_W-1:0]  sel_lvl;
   logic [TT_W-1:0]   cand_tt;
   logic              nest_block;
   logic [LEVELS:0]   thresh;
   logic              below;
   pil_act_e          act;

   logic              req_q;
   logic [TT_W-1:0]   idx_q;

   pil_pend_merge #(
      .LEVELS(LEVELS), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
      .STICK_BIT(STICK_BIT), .TMR_LEVEL(TMR_LEVEL), .TMR_REMAP(TMR_REMAP)
   ) u_merge (
      .ext_lvl (ext_lvl),
      .soft_int(soft_int),
      .pend    (pend)
   );

   pil_prio_scan #(
      .LEVELS(LEVELS), .FOLD_TREE(FOLD_TREE)
   ) u_scan (
      .pend     (pend),
      .floor_lvl(cur_lvl),
      .found    (found),
      .sel_lvl  (sel_lvl)
   );

   assign cand_tt = BASE_V | TT_W'(sel_lvl);

   pil_nest_gate #(
      .TT_W(TT_W), .TL_W(TL_W), .GRP_LSB(LVL_W), .EXT_BASE(EXT_BASE)
   ) u_nest (
      .trap_lvl(trap_lvl),
      .cur_tt  (cur_tt),
      .cand_tt (cand_tt),
      .block   (nest_block)
   );

   assign thresh = (LEVELS+1)'(2) << cur_lvl;
   assign below  = ({1'b0, pend} < thresh);

   always_comb begin
      act = ACT_HOLD;
      if (vec_busy) begin
         act = ACT_HOLD;
      end else if (below) begin
         act = ACT_CLEAR;
      end else if (!int_en) begin
         act = req_q ? ACT_CLEAR : ACT_HOLD;
      end else if (found && !nest_block && (cand_tt != idx_q)) begin
         act = ACT_SET;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
      end else begin
         unique case (act)
            ACT_CLEAR: begin
               req_q <= 1'b0;
               idx_q <= '0;
            end
            ACT_SET: begin
               req_q <= 1'b1;
               idx_q <= cand_tt;
            end
            default: begin
               req_q <= req_q;
               idx_q <= idx_q;
            end
         endcase
      end
   end

   assign hard_req = req_q;
   assign trap_idx = idx_q;
endmodule

// File: rtl/pil_irq_select_chk.sv
module pil_irq_select_chk #(
   parameter int unsigned LEVELS    = 16,
   parameter int unsigned TT_W      = 9,
   parameter int unsigned TL_W      = 3,
   parameter int unsigned EXT_BASE  = 'h040,
   parameter int unsigned TICK_BIT  = 0,
   parameter int unsigned STICK_BIT = 16,
   parameter int unsigned TMR_LEVEL = 14,
   localparam int unsigned LVL_W    = $clog2(LEVELS),
   localparam int unsigned SOFT_W   = LEVELS + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LEVELS-1:0] ext_lvl,
   input logic [SOFT_W-1:0] soft_int,
   input logic [LVL_W-1:0]  cur_lvl,
   input logic              int_en,
   input logic [TL_W-1:0]   trap_lvl,
   input logic [TT_W-1:0]   cur_tt,
   input logic              vec_busy,
   input logic              hard_req,
   input logic [TT_W-1:0]   trap_idx
);
   localparam logic [TT_W-1:0] BASE_V = TT_W'(EXT_BASE);

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_busy |=> ($stable(hard_req) && $stable(trap_idx))); // R3

   AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_busy && ext_lvl == '0 && soft_int == '0) |=> (!hard_req && trap_idx == '0)); // R4

   AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_busy && !int_en) |=> (!hard_req && trap_idx == '0)); // R8

   AST_CODE_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      hard_req |-> (trap_idx[TT_W-1:LVL_W] == BASE_V[TT_W-1:LVL_W]
                    && trap_idx[LVL_W-1:0] != '0)); // R5

   AST_TIMER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_busy && int_en && trap_lvl == '0 && cur_lvl == LVL_W'(TMR_LEVEL - 1)
       && ext_lvl[LEVELS-1:TMR_LEVEL+1] == '0
       && soft_int[LEVELS-1:TMR_LEVEL+1] == '0
       && (soft_int[TICK_BIT] || soft_int[STICK_BIT]))
      |=> (hard_req && trap_idx == (BASE_V | TT_W'(TMR_LEVEL)))); // R2

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> (!hard_req && trap_idx == '0)); // R9
endmodule

bind pil_irq_select pil_irq_select_chk #(
   .LEVELS(LEVELS), .TT_W(TT_W), .TL_W(TL_W), .EXT_BASE(EXT_BASE),
   .TICK_BIT(TICK_BIT), .STICK_BIT(STICK_BIT), .TMR_LEVEL(TMR_LEVEL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
   .cur_lvl(cur_lvl), .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
   .vec_busy(vec_busy), .hard_req(hard_req), .trap_idx(trap_idx)
);

// File: tb/tb_pil_irq_select.sv
module tb_pil_irq_select;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ext_lvl = '0;
   logic [16:0] soft_int = '0;
   logic [3:0]  cur_lvl = '0;
   logic        int_en = 1'b0;
   logic [2:0]  trap_lvl = '0;
   logic [8:0]  cur_tt = '0;
   logic        vec_busy = 1'b0;
   logic        hard_req;
   logic [8:0]  trap_idx;

   int total = 0;
   int bad = 0;

   logic       m_req = 1'b0;
   logic [8:0] m_idx = '0;
   string      m_tag = "R9";

   always #(PERIOD/2) clk = ~clk;

   pil_irq_select dut (
      .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
      .cur_lvl(cur_lvl), .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
      .vec_busy(vec_busy), .hard_req(hard_req), .trap_idx(trap_idx)
   );

   // Arithmetic reference: advances m_req/m_idx by one clock.
   task automatic model_step();
      logic [16:0] p;
      int          top;
      logic [8:0]  cand;
      p = {1'b0, ext_lvl | (soft_int[15:0] & 16'hFFFE)};
      if (soft_int[0] || soft_int[16]) p[14] = 1'b1;
      if (vec_busy) begin
         m_tag = "R3";
      end else if (p < (17'd2 << cur_lvl)) begin
         m_tag = "R4"; m_req = 1'b0; m_idx = '0;
      end else if (!int_en) begin
         m_tag = "R8"; m_req = 1'b0; m_idx = '0;
      end else begin
         top = 0;
         for (int i = 15; i >= 0; i--) if (p[i] && top == 0) top = i;
         cand = 9'h040 + 9'(top);
         if (trap_lvl != 0 && cur_tt[8:4] == 5'h04 && cur_tt > cand) m_tag = "R6";
         else if (cand == m_idx) m_tag = "R7";
         else begin
            m_tag = (top == 14 && !ext_lvl[14] && !soft_int[14]) ? "R2" : "R5";
            m_req = 1'b1; m_idx = cand;
         end
      end
   endtask

   task automatic check(input string tag);
      total++;
      if (hard_req !== m_req || trap_idx !== m_idx) begin
         bad++;
         $display("FAIL %s: req=%b idx=%h expected req=%b idx=%h", tag,
                  hard_req, trap_idx, m_req, m_idx);
      end
   endtask

   // Inputs already applied; clock once and compare at the following negedge.
   task automatic cycle(input string force_tag);
      model_step();
      @(negedge clk);
      check(force_tag == "" ? m_tag : force_tag);
   endtask

   task automatic clear_state();
      vec_busy = 0; ext_lvl = '0; soft_int = '0; cur_lvl = '0;
      cycle("R4");
   endtask

   initial begin
      #(PERIOD * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: req=%b idx=%h expected run to end", hard_req, trap_idx);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9");
      rst_n = 1'b1;
      int_en = 1'b1;

      // Mask level against every single-level request (R4/R5).
      for (int l = 0; l < 16; l++) begin
         for (int b = 0; b < 16; b++) begin
            cur_lvl = 4'(l); ext_lvl = 16'(1) << b;
            cycle(b > l ? "R5" : "R4");
         end
      end

      // Soft register one bit at a time (R1, R2).
      for (int b = 0; b < 17; b++) begin
         clear_state();
         soft_int = 17'(1) << b;
         cycle((b == 0 || b == 16) ? "R2" : "R1");
      end

      // Vectored busy freezes outputs (R3).
      clear_state();
      ext_lvl = 16'h0100; cycle("R5");
      vec_busy = 1; ext_lvl = 16'h8000; cycle("R3");
      int_en = 0; cycle("R3");
      ext_lvl = '0; cycle("R3");
      vec_busy = 0; int_en = 1; ext_lvl = 16'h8000; cycle("R5");

      // Same code again leaves outputs alone (R7).
      cycle("R7");

      // Disable drops the request (R8).
      int_en = 0; cycle("R8");
      int_en = 1;

      // Nesting sweep over current trap types (R6).
      for (int t = 'h038; t < 'h058; t++) begin
         for (int lv = 1; lv < 16; lv++) begin
            clear_state();
            trap_lvl = 3'd2; cur_tt = 9'(t); ext_lvl = 16'(1) << lv;
            cycle("");
         end
      end
      trap_lvl = '0;

      // Biased random mix against the model.
      for (int n = 0; n < 6000; n++) begin
         vec_busy = ($urandom % 8) == 0;
         int_en   = ($urandom % 8) != 0;
         trap_lvl = ($urandom % 2) ? 3'($urandom) : 3'd0;
         cur_tt   = ($urandom % 4) != 0 ? 9'(9'h040 | 9'($urandom % 16)) : 9'($urandom);
         cur_lvl  = 4'($urandom);
         ext_lvl  = 16'($urandom) & 16'($urandom) & 16'($urandom);
         soft_int = 17'($urandom) & 17'($urandom) & 17'($urandom) & 17'($urandom);
         cycle("");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule